// File: doc/BRIEF.md
# Serial EEPROM Address-Width Probe Sequencer

This block determines whether a serial EEPROM sitting on an I2C bus expects one or two address bytes in front of its data. It does not touch the bus wires itself. Instead it drives a byte-level I2C master through a small command channel. It issues start, repeated-start, write-byte, read-byte and stop commands, and it takes back one response per command. A response carries the acknowledge status and, for reads, the data byte.

A single `start` pulse launches a run of eight probes against the 7-bit device address on `dev_addr`. Each probe writes a zero byte followed by the probe number, with no stop after them. It then turns the bus round with a repeated start and reads a single byte, ending with a stop. A device with one address byte takes the zero as its pointer and the probe number as pending data. Because no stop follows, it never commits that data, and it returns the same location eight times. A device with two address bytes moves its pointer to a new location on every probe. If the eight bytes read back are identical, the result is one address byte. If any byte differs, the result is two address bytes. A missing acknowledge on any written byte ends the run early with a stop and an error flag.

Top module: `eeprom_awidth_probe`

## Requirements
- R1: A run consists of exactly `N_PROBES` (default 8) probes numbered 0 upward. In each probe the first written data byte is `HI_BYTE` (default 0x00) and the second is the probe number.
- R2: Every probe issues this command sequence in order: START (op 0), WRITE (op 2) of `{dev_addr,1'b0}`, WRITE of `HI_BYTE`, WRITE of the probe number, RSTART (op 1), WRITE of `{dev_addr,1'b1}`, one READ (op 3) with `cmd_rd_nack` high, and STOP (op 4).
- R3: During a run without errors, no STOP is issued between the written bytes and the repeated start. Every such STOP directly follows a READ.
- R4: When all read bytes of a run are equal, `done` rises with `two_byte` low.
- R5: When any read byte differs from the others, including only the first or only the last, `done` rises with `two_byte` high.
- R6: `done` rises only after the response to the final STOP, with `busy` low. `done`, `two_byte` and `nack_err` hold their values until the next accepted start.
- R7: A response with `rsp_nack` high to any WRITE makes the block issue one STOP (op 4) and no further probes. It then raises `done` and `nack_err` with `two_byte` low.
- R8: `start` is sampled only while the block is idle. A start pulse during a run has no effect on the command stream.
- R9: `cmd_valid` stays high with `cmd_op` and `cmd_wdata` unchanged until `cmd_ready` is seen. No new command is issued before the response to the previous one has arrived on `rsp_valid`.
- R10: After reset, `busy`, `done`, `nack_err`, `two_byte` and `cmd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a detection run (sampled while idle) |
| dev_addr | input | 7 | 7-bit I2C device address |
| cmd_valid | output | 1 | Command to the byte-level master is valid |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_op | output | 3 | 0 START, 1 RSTART, 2 WRITE, 3 READ, 4 STOP |
| cmd_wdata | output | 8 | Byte to write for WRITE commands |
| cmd_rd_nack | output | 1 | Answer the read byte with NACK |
| rsp_valid | input | 1 | One-cycle response for the accepted command |
| rsp_nack | input | 1 | Written byte was not acknowledged |
| rsp_rdata | input | 8 | Byte returned by a READ |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; result fields are valid |
| two_byte | output | 1 | Device needs two address bytes |
| nack_err | output | 1 | Run aborted on a missing acknowledge |

## Verification
The bench builds the block with its defaults: eight probes, a zero high byte, and a byte master model that answers every command two cycles after accepting it. That model imitates both a one-address-byte and a two-address-byte memory, with several content patterns. It also throttles `cmd_ready` on some runs. With this setup the following cases can be reached: the aliasing in which a two-byte device with uniform content reads as one-byte, mismatches that occur only on the first or the last probe, a stop that would commit a write on a one-byte device, and acknowledge failures injected at the first address byte and at a later probe number byte.

// File: rtl/eeprom_probe_pkg.sv
package eeprom_probe_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } i2c_op_e;

  // Steps of one probe, in bus order
  typedef enum logic [2:0] {
    SP_START  = 3'd0,
    SP_ADDR_W = 3'd1,
    SP_HI     = 3'd2,
    SP_IDX    = 3'd3,
    SP_RSTART = 3'd4,
    SP_ADDR_R = 3'd5,
    SP_READ   = 3'd6,
    SP_STOP   = 3'd7
  } probe_step_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_ISSUE,
    FS_WAIT,
    FS_ABORT_ISSUE,
    FS_ABORT_WAIT
  } fsm_state_e;

  function automatic logic [7:0] addr_byte(input logic [6:0] dev, input logic rd);
    return {dev, rd};
  endfunction

  function automatic i2c_op_e step_op(input probe_step_e s);
    case (s)
      SP_START:  return OP_START;
      SP_RSTART: return OP_RSTART;
      SP_READ:   return OP_READ;
      SP_STOP:   return OP_STOP;
      default:   return OP_WRITE;
    endcase
  endfunction

  // Steps whose response acknowledge status matters
  function automatic logic step_needs_ack(input probe_step_e s);
    return (s == SP_ADDR_W) || (s == SP_HI) || (s == SP_IDX) || (s == SP_ADDR_R);
  endfunction

endpackage

// File: rtl/probe_cmd_gen.sv
module probe_cmd_gen
  import eeprom_probe_pkg::*;
#(
  parameter int          IDX_W   = 3,
  parameter logic [7:0]  HI_BYTE = 8'h00
) (
  input  probe_step_e      step,
  input  logic [IDX_W-1:0] probe_idx,
  input  logic [6:0]       dev_addr,
  input  logic             aborting,
  output i2c_op_e          op,
  output logic [7:0]       wdata,
  output logic             rd_nack
);

  always_comb begin
    op      = aborting ? OP_STOP : step_op(step);
    wdata   = 8'h00;
    rd_nack = 1'b0;
    if (!aborting) begin
      case (step)
        SP_ADDR_W: wdata = addr_byte(dev_addr, 1'b0);
        SP_HI:     wdata = HI_BYTE;
        SP_IDX:    wdata = 8'(probe_idx);
        SP_ADDR_R: wdata = addr_byte(dev_addr, 1'b1);
        SP_READ:   rd_nack = 1'b1;
        default:   wdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/probe_compare.sv
module probe_compare #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              is_first,
  input  logic [DATA_W-1:0] rdata,
  output logic              differs
);

  logic [DATA_W-1:0] first_q;
  logic              mismatch;

  assign mismatch = capture && !is_first && (rdata != first_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      differs <= 1'b0;
    end else if (clear) begin
      first_q <= '0;
      differs <= 1'b0;
    end else if (capture) begin
      if (is_first) first_q <= rdata;
      else if (mismatch) differs <= 1'b1;
    end
  end

  // R5: a later byte unequal to the first sets the sticky flag
  a_r5_mismatch_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !is_first && !clear && rdata != first_q) |=> differs);

  // R5: flag never drops except on a new run
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (differs && !clear) |=> differs);

endmodule

// File: rtl/probe_fsm.sv
module probe_fsm
  import eeprom_probe_pkg::*;
#(
  parameter int N_PROBES = 8,
  parameter int IDX_W    = (N_PROBES > 1) ? $clog2(N_PROBES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmd_ready,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  output logic             cmd_valid,
  output probe_step_e      step,
  output logic [IDX_W-1:0] probe_idx,
  output logic             aborting,
  output logic             busy,
  output logic             done,
  output logic             nack_err,
  output logic             run_clear,
  output logic             rd_capture,
  output logic             first_probe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PROBES - 1);

  fsm_state_e state;

  logic in_wait, rsp_here, ack_fail, last_stop;

  assign in_wait   = (state == FS_WAIT);
  assign rsp_here  = in_wait && rsp_valid;
  assign ack_fail  = rsp_here && step_needs_ack(step) && rsp_nack;
  assign last_stop = rsp_here && (step == SP_STOP) && (probe_idx == LAST_IDX);

  assign cmd_valid   = (state == FS_ISSUE) || (state == FS_ABORT_ISSUE);
  assign aborting    = (state == FS_ABORT_ISSUE) || (state == FS_ABORT_WAIT);
  assign busy        = (state != FS_IDLE);
  assign run_clear   = (state == FS_IDLE) && start;
  assign rd_capture  = rsp_here && (step == SP_READ);
  assign first_probe = (probe_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      step      <= SP_START;
      probe_idx <= '0;
      done      <= 1'b0;
      nack_err  <= 1'b0;
    end else begin
      case (state)
        FS_IDLE: begin
          if (start) begin
            state     <= FS_ISSUE;
            step      <= SP_START;
            probe_idx <= '0;
            done      <= 1'b0;
            nack_err  <= 1'b0;
          end
        end
        FS_ISSUE: begin
          if (cmd_ready) state <= FS_WAIT;
        end
        FS_WAIT: begin
          if (rsp_valid) begin
            if (ack_fail) begin
              state <= FS_ABORT_ISSUE;
            end else if (step == SP_STOP) begin
              if (last_stop) begin
                state <= FS_IDLE;
                done  <= 1'b1;
              end else begin
                probe_idx <= probe_idx + 1'b1;
                step      <= SP_START;
                state     <= FS_ISSUE;
              end
            end else begin
              step  <= probe_step_e'(step + 3'd1);
              state <= FS_ISSUE;
            end
          end
        end
        FS_ABORT_ISSUE: begin
          if (cmd_ready) state <= FS_ABORT_WAIT;
        end
        FS_ABORT_WAIT: begin
          if (rsp_valid) begin
            state    <= FS_IDLE;
            done     <= 1'b1;
            nack_err <= 1'b1;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  // R6: completion is only reported while idle
  a_r6_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6: result stays until a start is accepted
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R7: an error is always accompanied by completion
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    nack_err |-> done);

  // R9: a pending command is not withdrawn
  a_r9_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid);

  // R1: probe counter never passes the last probe
  a_r1_probe_bound: assert property (@(posedge clk) disable iff (!rst_n)
    probe_idx <= LAST_IDX);

  // R8: a start during a run does not restart it
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !rsp_valid) |=> busy && $stable(probe_idx));

endmodule

// File: rtl/eeprom_awidth_probe.sv
module eeprom_awidth_probe
  import eeprom_probe_pkg::*;
#(
  parameter int         N_PROBES = 8,
  parameter logic [7:0] HI_BYTE  = 8'h00,
  localparam int        IDX_W    = (N_PROBES > 1) ? $clog2(N_PROBES) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [6:0] dev_addr,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [2:0] cmd_op,
  output logic [7:0] cmd_wdata,
  output logic       cmd_rd_nack,
  input  logic       rsp_valid,
  input  logic       rsp_nack,
  input  logic [7:0] rsp_rdata,
  output logic       busy,
  output logic       done,
  output logic       two_byte,
  output logic       nack_err
);

  probe_step_e      step;
  logic [IDX_W-1:0] probe_idx;
  logic             aborting, run_clear, rd_capture, first_probe, differs;
  i2c_op_e          op;
  logic             cmd_fire;
  i2c_op_e          last_op;

  probe_fsm #(.N_PROBES(N_PROBES), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_nack   (rsp_nack),
    .cmd_valid  (cmd_valid),
    .step       (step),
    .probe_idx  (probe_idx),
    .aborting   (aborting),
    .busy       (busy),
    .done       (done),
    .nack_err   (nack_err),
    .run_clear  (run_clear),
    .rd_capture (rd_capture),
    .first_probe(first_probe)
  );

  probe_cmd_gen #(.IDX_W(IDX_W), .HI_BYTE(HI_BYTE)) u_gen (
    .step     (step),
    .probe_idx(probe_idx),
    .dev_addr (dev_addr),
    .aborting (aborting),
    .op       (op),
    .wdata    (cmd_wdata),
    .rd_nack  (cmd_rd_nack)
  );

  probe_compare #(.DATA_W(8)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (run_clear),
    .capture (rd_capture),
    .is_first(first_probe),
    .rdata   (rsp_rdata),
    .differs (differs)
  );

  assign cmd_op   = op;
  assign two_byte = done && !nack_err && differs;
  assign cmd_fire = cmd_valid && cmd_ready;

  // Record of the last command handed to the master
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_op <= OP_STOP;
    else if (cmd_fire) last_op <= op;
  end

  // R3: outside an abort a STOP comes only after the READ
  a_r3_stop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && op == OP_STOP && !aborting) |-> last_op == OP_READ);

  // R3: the repeated start follows a written byte, never a STOP
  a_r3_rstart_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && op == OP_RSTART) |-> last_op == OP_WRITE);

  // R2: reads are always closed with NACK
  a_r2_read_nacked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_READ) |-> cmd_rd_nack);

  // R9: command content is stable while stalled
  a_r9_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ($stable(cmd_op) && $stable(cmd_wdata)));

  // R7: an error run never reports a width result
  a_r7_no_result_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nack_err) |-> !two_byte);

endmodule

// File: tb/eeprom_awidth_probe_tb.sv
module eeprom_awidth_probe_tb_top;
  import eeprom_probe_pkg::*;

  localparam int LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] dev_addr = 7'h50;
  logic       cmd_valid, cmd_ready, cmd_rd_nack;
  logic [2:0] cmd_op;
  logic [7:0] cmd_wdata;
  logic       rsp_valid, rsp_nack;
  logic [7:0] rsp_rdata;
  logic       busy, done, two_byte, nack_err;

  always #10 clk = ~clk;  // 50 MHz

  eeprom_awidth_probe dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_rd_nack(cmd_rd_nack),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata),
    .busy(busy), .done(done), .two_byte(two_byte), .nack_err(nack_err)
  );

  // Run settings, driven only by the stimulus process
  logic       two_mode = 1'b0;
  logic [1:0] pat = 2'd0;
  logic       stall_en = 1'b0;
  int         nack_at = -1;
  logic       clr_req = 1'b0;

  // Model state
  logic [7:0]  cyc = 8'd0;
  logic        pend = 1'b0;
  int          dly = 0;
  int          n_cmd = 0, n_stop = 0, n_idx = 0;
  int          tpos = 0;
  logic        is_rd = 1'b0;
  logic [7:0]  hi = 8'h00;
  logic [15:0] ptr = 16'h0;
  logic [2:0]  prev_op = 3'd4;
  logic        idx_bad = 1'b0, seq_bad = 1'b0, wc_viol = 1'b0, ovl = 1'b0;
  logic        rdnack_bad = 1'b0, addr_bad = 1'b0, stall_bad = 1'b0;
  logic        stalled = 1'b0;
  logic [2:0]  st_op = 3'd0;
  logic [7:0]  st_wd = 8'd0;

  assign cmd_ready = stall_en ? (cyc[1:0] == 2'b11) : 1'b1;

  function automatic logic [7:0] memf(input logic [1:0] p, input logic [15:0] a);
    case (p)
      2'd0:    return 8'hA5;
      2'd1:    return a[7:0] ^ 8'h3C;
      2'd2:    return (a == 16'd7) ? 8'h11 : 8'h22;
      default: return (a == 16'd0) ? 8'h11 : 8'h22;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (clr_req) begin
      pend <= 1'b0; rsp_valid <= 1'b0; rsp_nack <= 1'b0; rsp_rdata <= 8'h00;
      n_cmd <= 0; n_stop <= 0; n_idx <= 0; tpos <= 0; prev_op <= 3'd4;
      idx_bad <= 1'b0; seq_bad <= 1'b0; wc_viol <= 1'b0; ovl <= 1'b0;
      rdnack_bad <= 1'b0; addr_bad <= 1'b0; stall_bad <= 1'b0; stalled <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (pend) begin
        if (dly == 0) begin rsp_valid <= 1'b1; pend <= 1'b0; end
        else dly <= dly - 1;
      end
      if (stalled && (!cmd_valid || cmd_op != st_op || cmd_wdata != st_wd)) stall_bad <= 1'b1;
      stalled <= cmd_valid && !cmd_ready;
      st_op   <= cmd_op;
      st_wd   <= cmd_wdata;
      if (cmd_valid && cmd_ready) begin
        if (pend) ovl <= 1'b1;
        pend    <= 1'b1;
        dly     <= LAT;
        n_cmd   <= n_cmd + 1;
        prev_op <= cmd_op;
        rsp_nack <= 1'b0;
        case (cmd_op)
          3'd0, 3'd1: begin
            tpos <= 0;
            if (cmd_op == 3'd1 && !(prev_op == 3'd2 && tpos == 3)) seq_bad <= 1'b1;
          end
          3'd2: begin
            if (n_cmd == nack_at) rsp_nack <= 1'b1;
            if (tpos == 0) begin
              is_rd <= cmd_wdata[0];
              if (cmd_wdata[7:1] != dev_addr) addr_bad <= 1'b1;
            end else if (tpos == 1) begin
              hi <= cmd_wdata;
              if (cmd_wdata != 8'h00) seq_bad <= 1'b1;
              if (!two_mode) ptr <= {8'h00, cmd_wdata};
            end else if (tpos == 2) begin
              if (cmd_wdata != 8'(n_idx)) idx_bad <= 1'b1;
              n_idx <= n_idx + 1;
              if (two_mode) ptr <= {hi, cmd_wdata};
            end
            tpos <= tpos + 1;
          end
          3'd3: begin
            rsp_rdata <= memf(pat, ptr);
            ptr <= ptr + 16'd1;
            if (!cmd_rd_nack) rdnack_bad <= 1'b1;
          end
          default: begin
            n_stop <= n_stop + 1;
            if (prev_op == 3'd2 && !is_rd && tpos >= 2) wc_viol <= 1'b1;
            if (prev_op != 3'd3) seq_bad <= 1'b1;
          end
        endcase
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // two(1) pat(2) stall(1) dev(7) exp(1)
  localparam int NV = 6;
  localparam logic [11:0] VEC [0:NV-1] = '{
    {1'b0, 2'd1, 1'b0, 7'h50, 1'b0},  // one-byte, varied content: aliased reads
    {1'b1, 2'd1, 1'b0, 7'h50, 1'b1},  // two-byte, varied content
    {1'b1, 2'd0, 1'b1, 7'h57, 1'b0},  // two-byte, uniform content, stalls
    {1'b1, 2'd2, 1'b0, 7'h23, 1'b1},  // only last byte differs
    {1'b1, 2'd3, 1'b1, 7'h50, 1'b1},  // only first byte differs, stalls
    {1'b0, 2'd3, 1'b0, 7'h7F, 1'b0}   // one-byte, location 0 special
  };

  int gcyc = 0;

  task automatic run(input logic tm, input logic [1:0] p, input logic se,
                     input logic [6:0] dv, input int nk, input logic mid_start);
    int n;
    @(negedge clk);
    two_mode = tm; pat = p; stall_en = se; dev_addr = dv; nack_at = nk;
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000 && gcyc < 150000) begin
      @(negedge clk);
      n++; gcyc++;
      start = mid_start && (n == 30);
    end
    start = 1'b0;
    chk(done, "R6 watchdog/done", int'(done), 1);
    chk(!busy, "R6 busy low at done", int'(busy), 0);
    chk(!ovl && !stall_bad, "R9 handshake", int'(ovl) + 2 * int'(stall_bad), 0);
    chk(!addr_bad, "R2 address byte", int'(addr_bad), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !nack_err && !two_byte && !cmd_valid, "R10 reset state",
        int'({busy, done, nack_err, two_byte, cmd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !busy, "R10 idle after reset", int'({busy, cmd_valid}), 0);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][11], VEC[v][10:9], VEC[v][8], VEC[v][7:1], -1, 1'b0);
      chk(two_byte == VEC[v][0], (VEC[v][0] ? "R5 width result" : "R4 width result"),
          int'(two_byte), int'(VEC[v][0]));
      chk(!nack_err, "R7 no error", int'(nack_err), 0);
      chk(n_stop == 8 && n_cmd == 64, "R1 probe count", n_stop, 8);
      chk(!idx_bad && !seq_bad, "R1 index bytes", int'({idx_bad, seq_bad}), 0);
      chk(!wc_viol, "R3 no commit stop", int'(wc_viol), 0);
      chk(!rdnack_bad, "R2 read nack", int'(rdnack_bad), 0);
    end

    // R6: outputs held while idle
    repeat (20) @(negedge clk);
    chk(done && !two_byte, "R6 result held", int'({done, two_byte}), 2);

    // R8: start during a run is ignored
    run(1'b1, 2'd1, 1'b0, 7'h50, -1, 1'b1);
    chk(n_cmd == 64 && n_stop == 8, "R8 single run", n_cmd, 64);
    chk(two_byte, "R8 result intact", int'(two_byte), 1);

    // R7: nack on the first address byte
    run(1'b1, 2'd1, 1'b0, 7'h50, 1, 1'b0);
    chk(nack_err && !two_byte, "R7 abort flags", int'({nack_err, two_byte}), 2);
    chk(n_cmd == 3 && n_stop == 1, "R7 abort stop", n_cmd, 3);
    chk(prev_op == 3'd4, "R7 last op stop", int'(prev_op), 4);

    // R7: nack on the index byte of probe 5, with stalls
    run(1'b1, 2'd1, 1'b1, 7'h50, 43, 1'b0);
    chk(nack_err && !two_byte, "R7 late abort flags", int'({nack_err, two_byte}), 2);
    chk(n_cmd == 45 && n_stop == 6, "R7 late abort count", n_cmd, 45);
    repeat (10) @(negedge clk);
    chk(nack_err && done, "R6 error held", int'({nack_err, done}), 3);

    // R6: a new run clears the error
    run(1'b0, 2'd0, 1'b0, 7'h50, -1, 1'b0);
    chk(!nack_err && !two_byte, "R6 error cleared", int'({nack_err, two_byte}), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule